// File: doc/BRIEF.md
# Manchester Word Transmitter with Timeout and Loopback Monitor

This block turns 16-bit words from a protocol controller into a Manchester II serial stream for a dual-redundant serial bus. Each word is tagged as a command/status word or a data word. That tag selects the sync pattern. The block frames the word with sync and odd parity and shifts it out half-bit by half-bit. A single encoder feeds every bus output. Each output is gated by its own enable pin, so the controller chooses which buses carry the message.

Two monitors run alongside the encoder. The first is a fail-safe timer that counts consecutive transmitting clocks. When the count reaches the limit, it stops the transmitter and latches a timeout flag. The flag stays set until the controller pulses a clear pin. The second is a loopback checker. It takes each word as decoded back from the bus by the receive path and compares it with the word just sent. It pulses one flag on a mismatch and another flag when no echo arrives within a set window.

Words enter over a valid/ready stream. A word is taken on any clock where `in_valid` and `in_ready` are both high. While `in_ready` is low the source must hold its word, and the word may change freely while `in_valid` is low. The block holds at most one word beyond the one on the wire. This is what lets a stream of words go out with no gap between frames.

Top module: `mtx_manch_tx`

## Requirements
- R1: After reset, `in_ready` is high, `busy`, `tmo` and both loopback flags are low, and every bus output is low. `in_ready` is high whenever the block is idle and not timed out. A word taken while idle makes `busy` high from the next clock.
- R2: A frame lasts 20 bit times, and each bit time is 2·HALF_CLKS clocks. The frame starts in the clock after the word is taken. It opens with a 3-bit-time sync: a command word sends 1.5 bit times high then 1.5 low, and a data word sends the reverse. Then come the 16 data bits, most significant first. Last comes a parity bit chosen so that the data bits and parity together hold an odd number of ones.
- R3: Each data and parity bit is Manchester II coded. A 1 is sent high for the first half of its bit time and low for the second half. A 0 is sent low then high.
- R4: While a frame is in its last bit time and no word is held, `in_ready` is high and one further word can be taken. That word's frame starts in the clock right after the parity bit ends, so `busy` never drops between frames.
- R5: Bus output i follows the encoded line only while `bus_en[i]` is high, and is otherwise low. All outputs are low when nothing is being sent.
- R6: When `busy` has been high for MAX_TX_CLKS consecutive clocks, `tmo` rises and stays high. At the same edge the frame in progress and any held word are dropped. From then on the bus outputs stay low and `in_ready` stays low.
- R7: A one-clock pulse on `tmo_clr` clears `tmo` and restarts the timer, and the block then accepts words again.
- R8: After a frame ends, the first echo (`echo_valid` high) that arrives within ECHO_WIN clocks is compared with the sent word: data, command/data tag and parity bit. If any of them differ, `lb_mismatch` pulses for one clock, in the clock after the echo.
- R9: If no echo arrives within ECHO_WIN clocks of a frame's end, `lb_missing` pulses for one clock. It also pulses when the next frame ends while the previous one is still waiting for its echo.
- R10: An echo that arrives while no frame is awaiting one is ignored and raises neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word offered by the controller |
| in_ready | output | 1 | Block can take a word this clock |
| in_data | input | 16 | Word to send |
| in_cmd | input | 1 | 1 = command/status sync, 0 = data sync |
| busy | output | 1 | A frame is on the wire |
| bus_en | input | NBUS | Per-bus transmit enables |
| bus_out | output | NBUS | Gated Manchester line per bus |
| tmo_clr | input | 1 | Pulse to clear a latched timeout |
| tmo | output | 1 | Transmit timeout latched |
| echo_valid | input | 1 | Decoded echo word present |
| echo_data | input | 16 | Echoed data bits |
| echo_cmd | input | 1 | Echoed sync type |
| echo_par | input | 1 | Echoed parity bit |
| lb_mismatch | output | 1 | One-clock pulse: echo differs from sent word |
| lb_missing | output | 1 | One-clock pulse: echo absent |

## Verification
A stuck or mis-stepped half-bit counter or pattern register shows on the bus lines within one half bit time, as a level that differs from the framed and coded word. A wrong held-word state shows at the next frame boundary, either as a gap in `busy` or as a repeated or lost frame. A timer that counts wrong moves the rise of `tmo` away from exactly MAX_TX_CLKS clocks of continuous sending. A stale loopback expectation shows as a wrong or missing flag pulse one clock after the echo, or when the window closes. The bench therefore compares every port against its reference model on every clock.

// File: rtl/mtx_pkg.sv
`timescale 1ns/1ps
package mtx_pkg;
  localparam int unsigned MTX_DW         = 16;
  localparam int unsigned MTX_SYNC_BITS  = 3;
  localparam int unsigned MTX_FRAME_BITS = MTX_SYNC_BITS + MTX_DW + 1;
  localparam int unsigned MTX_HALVES     = 2 * MTX_FRAME_BITS;

  typedef struct packed {
    logic              is_cmd;
    logic              par;
    logic [MTX_DW-1:0] data;
  } mtx_word_t;

  // odd parity: data plus parity bit carries an odd count of ones
  function automatic logic odd_par(input logic [MTX_DW-1:0] d);
    return ~^d;
  endfunction

  function automatic mtx_word_t make_word(input logic [MTX_DW-1:0] d, input logic c);
    mtx_word_t w;
    w.is_cmd = c;
    w.par    = odd_par(d);
    w.data   = d;
    return w;
  endfunction
endpackage

// File: rtl/mtx_frame_ser.sv
`timescale 1ns/1ps
module mtx_frame_ser
  import mtx_pkg::*;
#(
  parameter int unsigned HALF_CLKS = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MTX_DW-1:0] in_data,
  input  logic              in_cmd,
  input  logic              inhibit,
  input  logic              abort,
  output logic              in_ready,
  output logic              line,
  output logic              busy,
  output logic              done,
  output mtx_word_t         done_word
);
  localparam int unsigned HALVES = MTX_HALVES;
  localparam int unsigned HW     = $clog2(HALVES);
  localparam int unsigned DIVW   = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam int unsigned SYNC_H = 2 * MTX_SYNC_BITS;

  // half-bit level pattern, first half-bit in the MSB
  function automatic logic [HALVES-1:0] build(input mtx_word_t w);
    logic [HALVES-1:0] p;
    p = '0;
    for (int s = 0; s < SYNC_H; s++) begin
      p[HALVES-1-s] = (s < MTX_SYNC_BITS) ? w.is_cmd : ~w.is_cmd;
    end
    for (int i = 0; i < MTX_DW; i++) begin
      p[HALVES-1-SYNC_H-2*i] = w.data[MTX_DW-1-i];
      p[HALVES-2-SYNC_H-2*i] = ~w.data[MTX_DW-1-i];
    end
    p[1] = w.par;
    p[0] = ~w.par;
    return p;
  endfunction

  logic              active;
  logic [HALVES-1:0] pat;
  logic [HW-1:0]     hcnt;
  logic [DIVW-1:0]   div;
  logic              pend_v;
  mtx_word_t         pend;
  mtx_word_t         cur;
  mtx_word_t         in_word;
  mtx_word_t         load_w;
  logic              half_end, frame_end, last_bit, acc, load_now;

  assign in_word   = make_word(in_data, in_cmd);
  assign half_end  = active && (div == DIVW'(HALF_CLKS - 1));
  assign frame_end = half_end && (hcnt == HW'(HALVES - 1));
  assign last_bit  = active && (hcnt >= HW'(HALVES - 2));
  assign in_ready  = !inhibit && (!active || (last_bit && !pend_v));
  assign acc       = in_valid && in_ready;
  assign load_now  = (frame_end && (pend_v || acc)) || (!active && acc);
  assign load_w    = pend_v ? pend : in_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pat    <= '0;
      hcnt   <= '0;
      div    <= '0;
      pend_v <= 1'b0;
      pend   <= '0;
      cur    <= '0;
    end else if (abort) begin
      active <= 1'b0;
      pat    <= '0;
      hcnt   <= '0;
      div    <= '0;
      pend_v <= 1'b0;
    end else if (load_now) begin
      active <= 1'b1;
      pat    <= build(load_w);
      cur    <= load_w;
      hcnt   <= '0;
      div    <= '0;
      pend_v <= 1'b0;
    end else if (frame_end) begin
      active <= 1'b0;
      pat    <= pat << 1;
      hcnt   <= '0;
      div    <= '0;
    end else if (active) begin
      if (half_end) begin
        pat  <= pat << 1;
        hcnt <= hcnt + 1'b1;
        div  <= '0;
      end else begin
        div <= div + 1'b1;
      end
      if (acc) begin
        pend   <= in_word;
        pend_v <= 1'b1;
      end
    end
  end

  assign line      = pat[HALVES-1];
  assign busy      = active;
  assign done      = frame_end;
  assign done_word = cur;
endmodule

// File: rtl/mtx_fail_timer.sv
`timescale 1ns/1ps
module mtx_fail_timer #(
  parameter int unsigned MAX_TX_CLKS = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_on,
  input  logic clr,
  output logic tmo,
  output logic trip
);
  localparam int unsigned CW = $clog2(MAX_TX_CLKS + 1);

  logic [CW-1:0] cnt;

  assign trip = tx_on && (cnt == CW'(MAX_TX_CLKS - 1)) && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      tmo <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      tmo <= 1'b0;
    end else begin
      if (trip) tmo <= 1'b1;
      cnt <= tx_on ? cnt + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/mtx_loop_chk.sv
`timescale 1ns/1ps
module mtx_loop_chk
  import mtx_pkg::*;
#(
  parameter int unsigned ECHO_WIN = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  mtx_word_t         done_word,
  input  logic              echo_valid,
  input  logic [MTX_DW-1:0] echo_data,
  input  logic              echo_cmd,
  input  logic              echo_par,
  output logic              mismatch,
  output logic              missing
);
  localparam int unsigned WW = (ECHO_WIN > 1) ? $clog2(ECHO_WIN) : 1;

  logic          armed;
  logic [WW-1:0] wcnt;
  mtx_word_t     expw;
  mtx_word_t     echo_w;

  assign echo_w.is_cmd = echo_cmd;
  assign echo_w.par    = echo_par;
  assign echo_w.data   = echo_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      wcnt     <= '0;
      expw     <= '0;
      mismatch <= 1'b0;
      missing  <= 1'b0;
    end else begin
      mismatch <= 1'b0;
      missing  <= 1'b0;
      if (armed) begin
        if (echo_valid) begin
          mismatch <= (echo_w != expw);
          armed    <= 1'b0;
        end else if (done) begin
          missing <= 1'b1;
        end else if (wcnt == WW'(ECHO_WIN - 1)) begin
          missing <= 1'b1;
          armed   <= 1'b0;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
      if (done) begin
        armed <= 1'b1;
        wcnt  <= '0;
        expw  <= done_word;
      end
    end
  end
endmodule

// File: rtl/mtx_manch_tx.sv
`timescale 1ns/1ps
module mtx_manch_tx
  import mtx_pkg::*;
#(
  parameter int unsigned NBUS        = 2,
  parameter int unsigned HALF_CLKS   = 25,
  parameter int unsigned MAX_TX_CLKS = 40000,
  parameter int unsigned ECHO_WIN    = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MTX_DW-1:0] in_data,
  input  logic              in_cmd,
  output logic              busy,
  input  logic [NBUS-1:0]   bus_en,
  output logic [NBUS-1:0]   bus_out,
  input  logic              tmo_clr,
  output logic              tmo,
  input  logic              echo_valid,
  input  logic [MTX_DW-1:0] echo_data,
  input  logic              echo_cmd,
  input  logic              echo_par,
  output logic              lb_mismatch,
  output logic              lb_missing
);
  logic      line, done, trip;
  mtx_word_t done_word;

  mtx_frame_ser #(.HALF_CLKS(HALF_CLKS)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_cmd    (in_cmd),
    .inhibit   (tmo),
    .abort     (trip),
    .in_ready  (in_ready),
    .line      (line),
    .busy      (busy),
    .done      (done),
    .done_word (done_word)
  );

  mtx_fail_timer #(.MAX_TX_CLKS(MAX_TX_CLKS)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .tx_on (busy),
    .clr   (tmo_clr),
    .tmo   (tmo),
    .trip  (trip)
  );

  mtx_loop_chk #(.ECHO_WIN(ECHO_WIN)) u_lb (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .done_word  (done_word),
    .echo_valid (echo_valid),
    .echo_data  (echo_data),
    .echo_cmd   (echo_cmd),
    .echo_par   (echo_par),
    .mismatch   (lb_mismatch),
    .missing    (lb_missing)
  );

  for (genvar g = 0; g < NBUS; g++) begin : g_gate
    assign bus_out[g] = line & bus_en[g] & ~tmo;
  end
endmodule

// File: rtl/mtx_manch_tx_chk.sv
`timescale 1ns/1ps
module mtx_manch_tx_chk #(
  parameter int unsigned NBUS = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            busy,
  input logic [NBUS-1:0] bus_out,
  input logic            tmo_clr,
  input logic            tmo,
  input logic            lb_mismatch,
  input logic            lb_missing
);
  a_r1_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !busy) |=> busy);

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_out == '0));

  a_r6_trip_drops_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo) |-> !busy);

  a_r6_tmo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && !tmo_clr) |=> tmo);

  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_clr |=> !tmo);

  a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !(lb_mismatch && lb_missing));
endmodule

bind mtx_manch_tx mtx_manch_tx_chk #(.NBUS(NBUS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .busy        (busy),
  .bus_out     (bus_out),
  .tmo_clr     (tmo_clr),
  .tmo         (tmo),
  .lb_mismatch (lb_mismatch),
  .lb_missing  (lb_missing)
);

// File: tb/sim_mtx_manch_tx.sv
`timescale 1ns/1ps
module sim_mtx_manch_tx;
  localparam int HALF  = 2;
  localparam int MAXC  = 200;
  localparam int WIN   = 6;
  localparam int FRAME = 40 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        in_cmd = 1'b0;
  logic        busy;
  logic [1:0]  bus_en = 2'b00;
  logic [1:0]  bus_out;
  logic        tmo_clr = 1'b0;
  logic        tmo;
  logic        echo_valid = 1'b0;
  logic [15:0] echo_data = '0;
  logic        echo_cmd = 1'b0;
  logic        echo_par = 1'b0;
  logic        lb_mismatch, lb_missing;

  always #2.5 clk = ~clk;

  mtx_manch_tx #(.NBUS(2), .HALF_CLKS(HALF), .MAX_TX_CLKS(MAXC), .ECHO_WIN(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_cmd(in_cmd), .busy(busy), .bus_en(bus_en),
    .bus_out(bus_out), .tmo_clr(tmo_clr), .tmo(tmo), .echo_valid(echo_valid),
    .echo_data(echo_data), .echo_cmd(echo_cmd), .echo_par(echo_par),
    .lb_mismatch(lb_mismatch), .lb_missing(lb_missing)
  );

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit          m_active, m_tmo, m_armed, m_mis, m_miss;
  int          m_pos, m_tcnt, m_wcnt;
  logic [15:0] m_data, m_edata;
  bit          m_cmd, m_ecmd, m_epar;
  logic [16:0] m_q[$];

  function automatic bit m_ready();
    return !m_tmo && (!m_active || (m_pos >= FRAME - 2*HALF && m_q.size() == 0));
  endfunction

  function automatic bit lvl(input logic [15:0] d, input bit c, input int pos);
    int h, k;
    bit p, b;
    h = pos / HALF;
    k = h / 2;
    if (k < 3) return c ? (h < 3) : (h >= 3);
    if (k < 19) begin
      b = d[15 - (k - 3)];
      return (h % 2 == 0) ? b : !b;
    end
    p = (($countones(d) % 2) == 0);
    return (h % 2 == 0) ? p : !p;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_tmo = 0; m_armed = 0; m_mis = 0; m_miss = 0;
      m_pos = 0; m_tcnt = 0; m_wcnt = 0; m_q.delete();
    end else begin
      bit acc, fin, tset;
      acc  = in_valid && m_ready();
      fin  = m_active && m_pos == FRAME - 1;
      tset = m_active && m_tcnt == MAXC - 1 && !tmo_clr;
      // loopback
      m_mis = 0; m_miss = 0;
      if (m_armed) begin
        if (echo_valid) begin
          m_mis = (echo_data != m_edata) || (echo_cmd != m_ecmd) || (echo_par != m_epar);
          m_armed = 0;
        end else if (fin) m_miss = 1;
        else if (m_wcnt == WIN - 1) begin m_miss = 1; m_armed = 0; end
        else m_wcnt++;
      end
      if (fin) begin
        m_armed = 1; m_wcnt = 0; m_edata = m_data; m_ecmd = m_cmd;
        m_epar = (($countones(m_data) % 2) == 0);
      end
      // timer
      if (tmo_clr) begin m_tmo = 0; m_tcnt = 0; end
      else begin
        if (tset) m_tmo = 1;
        m_tcnt = m_active ? m_tcnt + 1 : 0;
      end
      // serializer
      if (tset) begin
        m_active = 0; m_q.delete(); m_pos = 0;
      end else if (fin) begin
        if (m_q.size() > 0) begin
          {m_cmd, m_data} = m_q.pop_front(); m_pos = 0;
        end else if (acc) begin
          m_cmd = in_cmd; m_data = in_data; m_pos = 0;
        end else m_active = 0;
      end else if (m_active) begin
        m_pos++;
        if (acc) m_q.push_back({in_cmd, in_data});
      end else if (acc) begin
        m_active = 1; m_cmd = in_cmd; m_data = in_data; m_pos = 0;
      end
    end
  end

  // per-clock comparison and event counters
  int cnt_mis, cnt_miss, cnt_b1hi, cnt_anyhi, cnt_busy, cnt_rise;
  bit prev_busy = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      logic [1:0] eb;
      bit ln;
      ln = m_active ? lvl(m_data, m_cmd, m_pos) : 1'b0;
      eb = {ln & bus_en[1] & !m_tmo, ln & bus_en[0] & !m_tmo};
      check(in_ready == m_ready(), "R1/R4 in_ready", in_ready, m_ready());
      check(busy == m_active, "R1/R4 busy", busy, m_active);
      check(bus_out == eb, "R2/R3/R5 bus_out", bus_out, eb);
      check(tmo == m_tmo, "R6/R7 tmo", tmo, m_tmo);
      check(lb_mismatch == m_mis, "R8 lb_mismatch", lb_mismatch, m_mis);
      check(lb_missing == m_miss, "R9 lb_missing", lb_missing, m_miss);
      if (lb_mismatch) cnt_mis++;
      if (lb_missing) cnt_miss++;
      if (bus_out[1]) cnt_b1hi++;
      if (bus_out != 0) cnt_anyhi++;
      if (busy) cnt_busy++;
      if (busy && !prev_busy) cnt_rise++;
      prev_busy = busy;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send(input logic [15:0] d, input bit c);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = d; in_cmd = c;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic echo(input int dly, input bit fd, input bit fc, input bit fp);
    @(negedge clk);
    while (!m_armed) @(negedge clk);
    repeat (dly) @(negedge clk);
    echo_valid = 1;
    echo_data  = m_edata ^ (fd ? 16'h0100 : 16'h0000);
    echo_cmd   = m_ecmd ^ fc;
    echo_par   = m_epar ^ fp;
    @(negedge clk);
    echo_valid = 0;
  endtask

  task automatic settle();
    repeat (FRAME + 2 * WIN) @(negedge clk);
  endtask

  int c0, c1;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(in_ready == 1, "R1 ready after reset", in_ready, 1);
    check(busy == 0, "R1 busy after reset", busy, 0);
    check(bus_out == 0, "R1 bus idle after reset", bus_out, 0);
    check(tmo == 0, "R1 tmo after reset", tmo, 0);

    // R2/R3/R5/R8: command word on bus A only, correct echo
    bus_en = 2'b01; c0 = cnt_mis; c1 = cnt_miss; cnt_b1hi = 0;
    fork send(16'hA5C3, 1); echo(2, 0, 0, 0); join
    settle();
    check(cnt_mis == c0, "R8 good echo no mismatch", cnt_mis - c0, 0);
    check(cnt_miss == c1, "R9 good echo no missing", cnt_miss - c1, 0);
    check(cnt_b1hi == 0, "R5 disabled bus B silent", cnt_b1hi, 0);

    // R8: data, sync type and parity each corrupted
    bus_en = 2'b11; c0 = cnt_mis;
    fork send(16'h0001, 0); echo(1, 1, 0, 0); join
    settle();
    check(cnt_mis == c0 + 1, "R8 data mismatch", cnt_mis - c0, 1);
    c0 = cnt_mis;
    fork send(16'hFFFF, 1); echo(0, 0, 1, 0); join
    settle();
    check(cnt_mis == c0 + 1, "R8 sync type mismatch", cnt_mis - c0, 1);
    c0 = cnt_mis;
    fork send(16'h1234, 0); echo(WIN - 1, 0, 0, 1); join
    settle();
    check(cnt_mis == c0 + 1, "R8 parity mismatch", cnt_mis - c0, 1);

    // R9: no echo at all
    c1 = cnt_miss;
    send(16'h8000, 1);
    settle();
    check(cnt_miss == c1 + 1, "R9 missing echo", cnt_miss - c1, 1);

    // R4: back-to-back frames with no gap
    cnt_busy = 0; cnt_rise = 0; c0 = cnt_mis; c1 = cnt_miss;
    fork
      begin send(16'h7E81, 1); send(16'h0F0F, 0); end
      begin echo(3, 0, 0, 0); echo(3, 0, 0, 0); end
    join
    settle();
    check(cnt_rise == 1, "R4 busy rises once", cnt_rise, 1);
    check(cnt_busy == 2 * FRAME, "R4 busy cycles for two frames", cnt_busy, 2 * FRAME);
    check(cnt_mis == c0 && cnt_miss == c1, "R8/R9 back-to-back echoes clean",
          cnt_mis + cnt_miss - c0 - c1, 0);

    // R5: both buses disabled
    bus_en = 2'b00; cnt_anyhi = 0;
    fork send(16'hFFFF, 1); echo(2, 0, 0, 0); join
    settle();
    check(cnt_anyhi == 0, "R5 all buses disabled", cnt_anyhi, 0);

    // R10: stray echo while nothing awaits one
    c0 = cnt_mis; c1 = cnt_miss;
    @(negedge clk);
    echo_valid = 1; echo_data = 16'hDEAD; echo_cmd = 1; echo_par = 0;
    @(negedge clk);
    echo_valid = 0;
    repeat (4) @(negedge clk);
    check(cnt_mis == c0 && cnt_miss == c1, "R10 stray echo ignored",
          cnt_mis + cnt_miss - c0 - c1, 0);

    // R6: continuous stream exceeds the limit
    bus_en = 2'b11;
    send(16'h1111, 1); send(16'h2222, 0); send(16'h3333, 1);
    repeat (FRAME) @(negedge clk);
    check(tmo == 1, "R6 timeout latched", tmo, 1);
    check(in_ready == 0, "R6 ready low in timeout", in_ready, 0);
    check(busy == 0, "R6 frame dropped", busy, 0);
    check(bus_out == 0, "R6 buses silent", bus_out, 0);

    // R7: clear and resume
    tmo_clr = 1;
    @(negedge clk);
    tmo_clr = 0;
    check(tmo == 0, "R7 timeout cleared", tmo, 0);
    check(in_ready == 1, "R7 ready again", in_ready, 1);
    fork send(16'h4C4C, 0); echo(1, 0, 0, 0); join
    settle();
    check(tmo == 0, "R7 single frame after clear no timeout", tmo, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule